// File: doc/BRIEF.md
# Operand Readiness Latency Scoreboard

This block sits beside an instruction issue stage and answers one question each cycle: may the instruction on the request lines issue now? For every architectural register it keeps the number of cycles until a pending result can be consumed, which of the fixed-point pipes produces it, and whether that producer imposes a cross-pipe forwarding penalty. Separately, for every fixed-point pipe, it keeps the number of cycles that pipe stays occupied by an iterative divide.

The issue stage presents an instruction class, up to two source registers with valid bits, a destination register and a target fixed-point pipe. `ready_o` is a combinational answer in the same cycle. When the stage pulses `issue_i`, the destination's entry is reloaded from a latency picked by the class. If the class is a divide, the target pipe is also marked occupied. The block trusts the strobe and does not gate it with `ready_o`.

A same-pipe consumer may use a fixed-point result as soon as the latency has elapsed. A consumer in the other fixed-point pipe needs one extra cycle. Load and floating results carry no such penalty.

Top module: `opnd_ready_sb`

## Requirements
- R1: After reset every register is usable and no pipe is occupied, so `ready_o` is 1 for any request. A reset also discards any pending result or divide occupancy.
- R2: Class encodings and latencies L are: 0 simple fixed-point 1, 1 fixed-point load 2, 2 vector/float load 3, 3 multiply 4, 4 scalar float/fused 5, 5 vector float 6, 6 word divide 36, 7 doubleword divide 68. If the producer issues in cycle t, a same-pipe consumer of its destination is ready from cycle t+L and not before.
- R3: For producers of classes 0, 3, 6 and 7, a consumer whose request pipe differs from the producer's pipe becomes ready in cycle t+L+1.
- R4: For producers of classes 1, 2, 4 and 5, the consumer's pipe has no effect, and readiness starts in cycle t+L.
- R5: A divide (class 6 or 7) issued in cycle t to pipe p occupies p through cycle t+L-1. During that time a request of class 0, 3, 6 or 7 that targets p is not ready. Requests for the other pipe, and requests of classes 1, 2, 4 and 5, are unaffected.
- R6: A source whose valid bit is 0 has no effect on `ready_o`. Valid bit 0 belongs to the source in `req_src[3:0]`, and valid bit 1 to the source in `req_src[7:4]`.
- R7: Issuing to a destination that already has a pending result replaces it, and the new latency alone governs readiness.
- R8: Register 0 is tracked like every other register.
- R9: `ready_o` reflects the request lines in the same cycle, without a register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cls | input | 3 | Instruction class code (see R2) |
| req_src_vld | input | 2 | Per-source valid bits |
| req_src | input | 8 | Two 4-bit source register indices, source 0 in the low bits |
| req_dst | input | 4 | Destination register index |
| req_pipe | input | 1 | Target fixed-point pipe (0 or 1) |
| issue_i | input | 1 | Issue strobe: records the request's destination and occupancy |
| ready_o | output | 1 | All valid sources usable and target pipe free |

## Verification
The hardest case is the long divide window. The bench has to hold a pipe occupied for 36 and then 68 cycles. It must also show that the block frees the pipe in exactly the right cycle, and that it releases the destination a cycle later for a consumer in the other pipe. The directed stimulus issues each divide and then walks the window one cycle at a time with fixed-point requests. Early in the window it probes the other pipe and a floating class to confirm they are unaffected. A second subtle case is a short write replacing a pending long one to the same register. The vector table reaches it by issuing both in back-to-back cycles.

// File: rtl/opsb_pkg.sv
package opsb_pkg;

   typedef enum logic [2:0] {
      CLS_FX   = 3'd0,
      CLS_FXLD = 3'd1,
      CLS_VLD  = 3'd2,
      CLS_MUL  = 3'd3,
      CLS_FP   = 3'd4,
      CLS_VFP  = 3'd5,
      CLS_DIVW = 3'd6,
      CLS_DIVD = 3'd7
   } op_class_e;

   // Result produced inside a fixed-point pipe (forwarding penalty across pipes)
   function automatic logic on_fx_pipe(op_class_e c);
      return (c == CLS_FX) || (c == CLS_MUL) || (c == CLS_DIVW) || (c == CLS_DIVD);
   endfunction

   function automatic logic is_divide(op_class_e c);
      return (c == CLS_DIVW) || (c == CLS_DIVD);
   endfunction

   function automatic int max_of(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/opsb_lat_sel.sv
module opsb_lat_sel
   import opsb_pkg::*;
#(
   parameter int CNT_W    = 7,
   parameter int LAT_FX   = 1,
   parameter int LAT_FXLD = 2,
   parameter int LAT_VLD  = 3,
   parameter int LAT_MUL  = 4,
   parameter int LAT_FP   = 5,
   parameter int LAT_VFP  = 6,
   parameter int LAT_DIVW = 36,
   parameter int LAT_DIVD = 68
) (
   input  op_class_e        cls_i,
   output logic [CNT_W-1:0] lat_o
);

   always_comb begin
      unique case (cls_i)
         CLS_FX:   lat_o = CNT_W'(LAT_FX);
         CLS_FXLD: lat_o = CNT_W'(LAT_FXLD);
         CLS_VLD:  lat_o = CNT_W'(LAT_VLD);
         CLS_MUL:  lat_o = CNT_W'(LAT_MUL);
         CLS_FP:   lat_o = CNT_W'(LAT_FP);
         CLS_VFP:  lat_o = CNT_W'(LAT_VFP);
         CLS_DIVW: lat_o = CNT_W'(LAT_DIVW);
         default:  lat_o = CNT_W'(LAT_DIVD);
      endcase
   end

endmodule

// File: rtl/opsb_reg_entry.sv
module opsb_reg_entry #(
   parameter int CNT_W   = 7,
   parameter int NPIPES  = 2,
   parameter int PIPE_W  = 1,
   parameter int MAX_LAT = 68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CNT_W-1:0]  load_lat_i,
   input  logic [PIPE_W-1:0] load_pipe_i,
   input  logic              load_xpen_i,
   output logic [NPIPES-1:0] rdy_o
);

   logic [CNT_W-1:0]  cnt_q;
   logic [PIPE_W-1:0] pipe_q;
   logic              xpen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pipe_q <= '0;
         xpen_q <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= load_lat_i;
         pipe_q <= load_pipe_i;
         xpen_q <= load_xpen_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // Counter value 1 means usable by the producing pipe (self-bypass);
   // value 0 means usable everywhere.
   for (genvar p = 0; p < NPIPES; p++) begin : g_cons
      logic far_side;
      assign far_side = xpen_q && (pipe_q != PIPE_W'(p));
      assign rdy_o[p] = (cnt_q == '0) || ((cnt_q == CNT_W'(1)) && !far_side);
   end

   // R2
   reload_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (load_lat_i > CNT_W'(1))) |=> (rdy_o == '0));

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_LAT));

endmodule

// File: rtl/opsb_pipe_busy.sv
module opsb_pipe_busy #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             busy_o
);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         left_q <= '0;
      else if (start_i)
         left_q <= len_i - CNT_W'(1);
      else if (left_q != '0)
         left_q <= left_q - CNT_W'(1);
   end

   assign busy_o = (left_q != '0);

   // R5
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (len_i > CNT_W'(1))) |=> busy_o);

   // R5
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/opsb_src_pick.sv
module opsb_src_pick #(
   parameter int NREGS  = 16,
   parameter int NPIPES = 2,
   parameter int AW     = 4,
   parameter int PIPE_W = 1
) (
   input  logic [NREGS-1:0][NPIPES-1:0] rdy_tbl_i,
   input  logic [AW-1:0]                idx_i,
   input  logic [PIPE_W-1:0]            pipe_i,
   input  logic                         vld_i,
   output logic                         ok_o
);

   logic [NPIPES-1:0] row;

   assign row  = rdy_tbl_i[idx_i];
   assign ok_o = !vld_i || row[pipe_i];

endmodule

// File: rtl/opnd_ready_sb.sv
module opnd_ready_sb
   import opsb_pkg::*;
#(
   parameter int NREGS    = 16,
   parameter int NSRC     = 2,
   parameter int NPIPES   = 2,
   parameter int LAT_FX   = 1,
   parameter int LAT_FXLD = 2,
   parameter int LAT_VLD  = 3,
   parameter int LAT_MUL  = 4,
   parameter int LAT_FP   = 5,
   parameter int LAT_VFP  = 6,
   parameter int LAT_DIVW = 36,
   parameter int LAT_DIVD = 68,
   localparam int AW      = $clog2(NREGS),
   localparam int PIPE_W  = $clog2(NPIPES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           req_cls,
   input  logic [NSRC-1:0]      req_src_vld,
   input  logic [NSRC*AW-1:0]   req_src,
   input  logic [AW-1:0]        req_dst,
   input  logic [PIPE_W-1:0]    req_pipe,
   input  logic                 issue_i,
   output logic                 ready_o
);

   localparam int MAX_LAT = max_of(max_of(max_of(LAT_FX, LAT_FXLD), max_of(LAT_VLD, LAT_MUL)),
                                   max_of(max_of(LAT_FP, LAT_VFP), max_of(LAT_DIVW, LAT_DIVD)));
   localparam int CNT_W   = $clog2(MAX_LAT + 1);

   // elaboration-time parameter checks
   if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("NREGS must be a power of two of at least 2");
   end
   if (NPIPES < 2 || (NPIPES & (NPIPES - 1)) != 0) begin : g_bad_npipes
      $error("NPIPES must be a power of two of at least 2");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("NSRC must be at least 1");
   end
   if (LAT_FX < 1 || LAT_FXLD < 1 || LAT_VLD < 1 || LAT_MUL < 1 ||
       LAT_FP < 1 || LAT_VFP < 1 || LAT_DIVW < 2 || LAT_DIVD < 2) begin : g_bad_lat
      $error("latencies must be positive and divides at least 2");
   end

   op_class_e        cls;
   logic [CNT_W-1:0] lat;
   logic             xpen;
   logic             div_req;
   logic             fx_req;

   assign cls     = op_class_e'(req_cls);
   assign xpen    = on_fx_pipe(cls);
   assign div_req = is_divide(cls);
   assign fx_req  = on_fx_pipe(cls);

   opsb_lat_sel #(
      .CNT_W(CNT_W), .LAT_FX(LAT_FX), .LAT_FXLD(LAT_FXLD), .LAT_VLD(LAT_VLD),
      .LAT_MUL(LAT_MUL), .LAT_FP(LAT_FP), .LAT_VFP(LAT_VFP),
      .LAT_DIVW(LAT_DIVW), .LAT_DIVD(LAT_DIVD)
   ) i_lat (
      .cls_i (cls),
      .lat_o (lat)
   );

   // per-register pending-result entries
   logic [NREGS-1:0][NPIPES-1:0] rdy_tbl;

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      logic hit;
      assign hit = issue_i && (req_dst == AW'(r));
      opsb_reg_entry #(
         .CNT_W(CNT_W), .NPIPES(NPIPES), .PIPE_W(PIPE_W), .MAX_LAT(MAX_LAT)
      ) i_entry (
         .clk         (clk),
         .rst_n       (rst_n),
         .load_i      (hit),
         .load_lat_i  (lat),
         .load_pipe_i (req_pipe),
         .load_xpen_i (xpen),
         .rdy_o       (rdy_tbl[r])
      );
   end

   // per-pipe divide occupancy
   logic [NPIPES-1:0] pipe_busy;

   for (genvar p = 0; p < NPIPES; p++) begin : g_pipe
      logic start;
      assign start = issue_i && div_req && (req_pipe == PIPE_W'(p));
      opsb_pipe_busy #(.CNT_W(CNT_W)) i_busy (
         .clk     (clk),
         .rst_n   (rst_n),
         .start_i (start),
         .len_i   (lat),
         .busy_o  (pipe_busy[p])
      );
   end

   // per-source readiness lookup
   logic [NSRC-1:0] src_ok;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      opsb_src_pick #(
         .NREGS(NREGS), .NPIPES(NPIPES), .AW(AW), .PIPE_W(PIPE_W)
      ) i_pick (
         .rdy_tbl_i (rdy_tbl),
         .idx_i     (req_src[s*AW +: AW]),
         .pipe_i    (req_pipe),
         .vld_i     (req_src_vld[s]),
         .ok_o      (src_ok[s])
      );
   end

   logic blocked;
   assign blocked = fx_req && pipe_busy[req_pipe];
   assign ready_o = (&src_ok) && !blocked;

   // R5
   blocked_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fx_req && pipe_busy[req_pipe]) |-> !ready_o);

   // R6
   no_src_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_src_vld == '0) && !fx_req) |-> ready_o);

endmodule

// File: tb/test_opnd_ready_sb.sv
`timescale 1ns/1ps
module test_opnd_ready_sb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] req_cls = '0;
   logic [1:0] req_src_vld = '0;
   logic [7:0] req_src = '0;
   logic [3:0] req_dst = '0;
   logic       req_pipe = 1'b0;
   logic       issue_i = 1'b0;
   logic       ready_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   opnd_ready_sb i_opnd_ready_sb (
      .clk(clk), .rst_n(rst_n), .req_cls(req_cls), .req_src_vld(req_src_vld),
      .req_src(req_src), .req_dst(req_dst), .req_pipe(req_pipe),
      .issue_i(issue_i), .ready_o(ready_o)
   );

   // row: cls[19:17] dst[16:13] s0[12:9] s1[8:5] vld[4:3] pipe[2] iss[1] exp[0]
   localparam int NROWS = 21;
   localparam logic [19:0] TBL [NROWS] = '{
      {3'd0, 4'd1, 4'd0, 4'd0, 2'b00, 1'b0, 1'b1, 1'b1},  // 0 issue fx r1 p0
      {3'd0, 4'd0, 4'd1, 4'd0, 2'b01, 1'b1, 1'b0, 1'b0},  // 1 R3 cross k=1
      {3'd0, 4'd0, 4'd1, 4'd0, 2'b01, 1'b1, 1'b0, 1'b1},  // 2 R3 cross k=2
      {3'd1, 4'd2, 4'd0, 4'd0, 2'b00, 1'b0, 1'b1, 1'b1},  // 3 issue fx load r2
      {3'd0, 4'd0, 4'd2, 4'd0, 2'b01, 1'b1, 1'b0, 1'b0},  // 4 R4 k=1
      {3'd0, 4'd0, 4'd2, 4'd0, 2'b01, 1'b1, 1'b0, 1'b1},  // 5 R4 k=2
      {3'd3, 4'd0, 4'd0, 4'd0, 2'b00, 1'b1, 1'b1, 1'b1},  // 6 issue mul r0 p1
      {3'd0, 4'd0, 4'd0, 4'd0, 2'b01, 1'b1, 1'b0, 1'b0},  // 7 R8 k=1
      {3'd0, 4'd0, 4'd0, 4'd0, 2'b01, 1'b1, 1'b0, 1'b0},  // 8 R8 k=2
      {3'd0, 4'd0, 4'd0, 4'd0, 2'b01, 1'b1, 1'b0, 1'b0},  // 9 R8 k=3
      {3'd0, 4'd0, 4'd0, 4'd0, 2'b01, 1'b0, 1'b0, 1'b0},  // 10 R3 cross k=4
      {3'd0, 4'd0, 4'd0, 4'd0, 2'b01, 1'b0, 1'b0, 1'b1},  // 11 R3 cross k=5
      {3'd5, 4'd3, 4'd0, 4'd0, 2'b00, 1'b0, 1'b1, 1'b1},  // 12 issue vfp r3
      {3'd0, 4'd3, 4'd0, 4'd0, 2'b00, 1'b0, 1'b1, 1'b1},  // 13 R7 overwrite r3
      {3'd0, 4'd0, 4'd3, 4'd0, 2'b01, 1'b0, 1'b0, 1'b1},  // 14 R7 k=1
      {3'd4, 4'd4, 4'd0, 4'd0, 2'b00, 1'b0, 1'b1, 1'b1},  // 15 issue fp r4
      {3'd0, 4'd0, 4'd4, 4'd0, 2'b00, 1'b0, 1'b0, 1'b1},  // 16 R6 invalid src
      {3'd0, 4'd0, 4'd0, 4'd4, 2'b10, 1'b0, 1'b0, 1'b0},  // 17 R6 src1 k=2
      {3'd0, 4'd0, 4'd1, 4'd4, 2'b11, 1'b1, 1'b0, 1'b0},  // 18 k=3
      {3'd0, 4'd0, 4'd1, 4'd4, 2'b11, 1'b1, 1'b0, 1'b0},  // 19 k=4
      {3'd0, 4'd0, 4'd1, 4'd4, 2'b11, 1'b1, 1'b0, 1'b1}   // 20 R4 k=5
   };

   task automatic check(input logic exp, input string req);
      checks++;
      if (ready_o !== exp) begin
         failures++;
         $display("FAIL %s: ready_o=%0b expected=%0b at %0t", req, ready_o, exp, $time);
      end
   endtask

   task automatic drive(input logic [2:0] cls, input logic [3:0] dst, input logic [3:0] s0,
                        input logic [3:0] s1, input logic [1:0] vld, input logic pipe,
                        input logic iss);
      @(negedge clk);
      req_cls = cls; req_dst = dst; req_src = {s1, s0};
      req_src_vld = vld; req_pipe = pipe; issue_i = iss;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state, every register and pipe free
      drive(3'd0, 4'd0, 4'd0, 4'd15, 2'b11, 1'b0, 1'b0); check(1'b1, "R1 reset r0/r15");
      drive(3'd7, 4'd0, 4'd7, 4'd9, 2'b11, 1'b1, 1'b0); check(1'b1, "R1 reset r7/r9 p1");

      // vector table, one row per cycle (R2 R3 R4 R6 R7 R8 R9)
      for (int i = 0; i < NROWS; i++) begin
         logic [19:0] row;
         row = TBL[i];
         drive(row[19:17], row[16:13], row[12:9], row[8:5], row[4:3], row[2], row[1]);
         check(row[0], $sformatf("R2/R9 table row %0d", i));
      end

      // R2: vector load latency 3
      drive(3'd2, 4'd6, 4'd0, 4'd0, 2'b00, 1'b0, 1'b1);
      drive(3'd0, 4'd0, 4'd6, 4'd0, 2'b01, 1'b1, 1'b0); check(1'b0, "R2 vld k=1");
      drive(3'd0, 4'd0, 4'd6, 4'd0, 2'b01, 1'b1, 1'b0); check(1'b0, "R2 vld k=2");
      drive(3'd0, 4'd0, 4'd6, 4'd0, 2'b01, 1'b1, 1'b0); check(1'b1, "R2 vld k=3");

      // R5: word divide on pipe 0 into r5
      drive(3'd6, 4'd5, 4'd0, 4'd0, 2'b00, 1'b0, 1'b1);
      drive(3'd0, 4'd0, 4'd0, 4'd0, 2'b00, 1'b1, 1'b0); check(1'b1, "R5 other pipe free");
      drive(3'd4, 4'd0, 4'd0, 4'd0, 2'b00, 1'b0, 1'b0); check(1'b1, "R5 float class free");
      for (int k = 3; k <= 35; k++) begin
         drive(3'd0, 4'd0, 4'd0, 4'd0, 2'b00, 1'b0, 1'b0);
         check(1'b0, $sformatf("R5 divw occupied k=%0d", k));
      end
      drive(3'd0, 4'd0, 4'd5, 4'd0, 2'b01, 1'b0, 1'b0); check(1'b1, "R5 R2 divw done k=36");

      // R5 R3: doubleword divide on pipe 1 into r7
      drive(3'd7, 4'd7, 4'd0, 4'd0, 2'b00, 1'b1, 1'b1);
      for (int k = 1; k <= 67; k++) begin
         drive(3'd3, 4'd0, 4'd0, 4'd0, 2'b00, 1'b1, 1'b0);
         check(1'b0, $sformatf("R5 divd occupied k=%0d", k));
      end
      drive(3'd0, 4'd0, 4'd7, 4'd0, 2'b01, 1'b0, 1'b0); check(1'b0, "R3 divd cross k=68");
      drive(3'd0, 4'd0, 4'd7, 4'd0, 2'b01, 1'b0, 1'b0); check(1'b1, "R3 divd cross k=69");

      // R1: reset discards pending divide and result
      drive(3'd7, 4'd8, 4'd0, 4'd0, 2'b00, 1'b0, 1'b1);
      drive(3'd0, 4'd0, 4'd0, 4'd0, 2'b00, 1'b0, 1'b0);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      drive(3'd0, 4'd0, 4'd8, 4'd0, 2'b01, 1'b0, 1'b0); check(1'b1, "R1 reset clears pending");

      drive(3'd0, 4'd0, 4'd0, 4'd0, 2'b00, 1'b0, 1'b0);
      finish_run();
   end

endmodule